// File: doc/BRIEF.md
# Threshold-Driven Transfer Buffer with DMA Requests

This block is a 32-entry, 16-bit circular buffer that sits between a host register port and a card-side data path. The transfer direction selects which side fills the buffer and which side drains it. When data flows from the card to the host, the host side pops and the card side pushes. When data flows from the host to the card, the roles swap. Strobes from the side that does not own an operation in the current direction are ignored.

Two programmable thresholds watch the occupancy. A high-water threshold applies only to card-to-host traffic. A low-water threshold applies only to host-to-card traffic. When a threshold condition holds, the block raises a DMA request for that direction if DMA is enabled for it. If DMA is not enabled, it raises a level status flag for software instead. A small fill-state machine (`FILL_EMPTY`, `FILL_PARTIAL`, `FILL_FULL`) decides which push and pop strobes are accepted. The transitions follow the occupancy after each edge: it reaches 0 in `FILL_EMPTY`, reaches 32 in `FILL_FULL`, and takes any other value in `FILL_PARTIAL`. The level evaluator picks one of three modes every cycle:
- `LM_IDLE`: no transfer is active and the buffer will be empty.
- `LM_RX`: card-to-host.
- `LM_TX`: host-to-card.

Top module: `lvl_fifo_top`

## Requirements
- R1: The buffer holds 32 entries of 16 bits. It returns them in write order, including when the read and write pointers wrap modulo 32. `occupancy` reports the entry count, from 0 to 32. `head_data` shows the oldest entry.
- R2: With `dir_rx`=1 (card-to-host), `card_push` writes `card_wdata` and `host_pop` removes the head. With `dir_rx`=0 (host-to-card), `host_push` writes `host_wdata` and `card_pop` removes the head. The other two strobes have no effect on occupancy or contents.
- R3: A push while occupancy is 32 is dropped, unless a pop is accepted in the same cycle.
- R4: A pop while the buffer is empty leaves occupancy at 0 and the pointers unchanged. `head_data` keeps showing the entry at the read pointer.
- R5: When a push and a pop are both accepted in one cycle, occupancy is unchanged.
- R6: When `dir_rx`=1 and occupancy is strictly greater than the high-water threshold, `rx_dma_req` is 1 if receive DMA is enabled, and `af_flag` is 1 otherwise. When the condition fails, both are 0.
- R7: When `dir_rx`=0 and occupancy is strictly less than the low-water threshold, `tx_dma_req` is 1 if transmit DMA is enabled, and `ae_flag` is 1 otherwise. When the condition fails, both are 0.
- R8: When `xfer_active`=0 and the buffer is empty, all four of `af_flag`, `ae_flag`, `rx_dma_req` and `tx_dma_req` are 0.
- R9: After reset, occupancy is 0, the high-water threshold is 31, the low-water threshold is 0, both DMA enables are off, and all four level outputs are 0.
- R10: The level outputs are registered. After a clock edge, they reflect the occupancy and configuration that hold after that same edge. A `cfg_wr` that sets a DMA enable therefore clears the matching flag at the same edge that loads the enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dir_rx | input | 1 | 1 = card-to-host, 0 = host-to-card |
| xfer_active | input | 1 | A data transfer is in progress |
| host_push | input | 1 | Host write strobe (host-to-card only) |
| host_wdata | input | 16 | Host write data |
| host_pop | input | 1 | Host read strobe (card-to-host only) |
| card_push | input | 1 | Card-side write strobe (card-to-host only) |
| card_wdata | input | 16 | Card-side write data |
| card_pop | input | 1 | Card-side read strobe (host-to-card only) |
| cfg_wr | input | 1 | Load the threshold and DMA-enable settings |
| cfg_af_level | input | 5 | High-water threshold to load |
| cfg_ae_level | input | 5 | Low-water threshold to load |
| cfg_rx_dma | input | 1 | Receive DMA enable to load |
| cfg_tx_dma | input | 1 | Transmit DMA enable to load |
| occupancy | output | 6 | Number of stored entries |
| head_data | output | 16 | Entry at the read pointer |
| rx_dma_req | output | 1 | Receive DMA request |
| tx_dma_req | output | 1 | Transmit DMA request |
| af_flag | output | 1 | High-water level status flag |
| ae_flag | output | 1 | Low-water level status flag |

## Verification
Occupancy and the four level outputs change at the same edge that accepts a strobe or a configuration write. `head_data` follows the read pointer updated at that edge with no further delay. The bench therefore applies a stimulus, waits for one rising edge, and samples one nanosecond later. It compares the outputs against a model that has been advanced by exactly that one edge. The sweeps step occupancy through every value from 0 to 32 for every threshold setting, so each strict comparison is exercised on both sides of its boundary.

// File: rtl/lvl_fifo_pkg.sv
`timescale 1ns/1ps
package lvl_fifo_pkg;

    // Fill state of the buffer after each edge
    typedef enum logic [1:0] {
        FILL_EMPTY   = 2'd0,
        FILL_PARTIAL = 2'd1,
        FILL_FULL    = 2'd2
    } fill_state_e;

    // Which threshold (if any) is active this cycle
    typedef enum logic [1:0] {
        LM_IDLE = 2'd0,
        LM_RX   = 2'd1,
        LM_TX   = 2'd2
    } lvl_mode_e;

endpackage

// File: rtl/lvl_fifo_store.sv
`timescale 1ns/1ps
module lvl_fifo_store #(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    output logic [DATA_W-1:0] head
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];
    logic [ADDR_W-1:0] wr_ptr;
    logic [ADDR_W-1:0] rd_ptr;

    // Pointers wrap naturally at DEPTH
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else begin
            if (wr_en) wr_ptr <= wr_ptr + 1'b1;
            if (rd_en) rd_ptr <= rd_ptr + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_ptr] <= wr_data;
    end

    assign head = mem[rd_ptr];

endmodule

// File: rtl/lvl_fifo_fill.sv
`timescale 1ns/1ps
module lvl_fifo_fill
    import lvl_fifo_pkg::*;
#(
    parameter int ADDR_W = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            push_req,
    input  logic            pop_req,
    output logic            push_ok,
    output logic            pop_ok,
    output logic [ADDR_W:0] count,
    output logic [ADDR_W:0] count_nxt
);
    localparam int CNT_W = ADDR_W + 1;
    localparam int DEPTH = 1 << ADDR_W;
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    fill_state_e state_q;
    fill_state_e state_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= FILL_EMPTY;
            count   <= '0;
        end else begin
            state_q <= state_d;
            count   <= count_nxt;
        end
    end

    // Acceptance decisions per state
    always_comb begin
        push_ok = 1'b0;
        pop_ok  = 1'b0;
        unique case (state_q)
            FILL_EMPTY: begin
                push_ok = push_req;
            end
            FILL_PARTIAL: begin
                push_ok = push_req;
                pop_ok  = pop_req;
            end
            FILL_FULL: begin
                pop_ok  = pop_req;
                push_ok = push_req && pop_req;
            end
            default: begin
                push_ok = 1'b0;
                pop_ok  = 1'b0;
            end
        endcase
    end

    // Next count and next state
    always_comb begin
        count_nxt = count + CNT_W'(push_ok) - CNT_W'(pop_ok);
        if (count_nxt == '0)
            state_d = FILL_EMPTY;
        else if (count_nxt == FULL_CNT)
            state_d = FILL_FULL;
        else
            state_d = FILL_PARTIAL;
    end

endmodule

// File: rtl/lvl_fifo_level.sv
`timescale 1ns/1ps
module lvl_fifo_level
    import lvl_fifo_pkg::*;
#(
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W:0]   count_nxt,
    input  logic              dir_rx,
    input  logic              xfer_active,
    input  logic [ADDR_W-1:0] af_lvl,
    input  logic [ADDR_W-1:0] ae_lvl,
    input  logic              rx_en,
    input  logic              tx_en,
    output logic              rx_req,
    output logic              tx_req,
    output logic              af_flag,
    output logic              ae_flag
);
    lvl_mode_e mode;
    logic      rx_hit;
    logic      tx_hit;
    logic      rx_req_d, tx_req_d, af_d, ae_d;

    always_comb begin
        if (!xfer_active && count_nxt == '0)
            mode = LM_IDLE;
        else if (dir_rx)
            mode = LM_RX;
        else
            mode = LM_TX;
    end

    assign rx_hit = count_nxt > {1'b0, af_lvl};
    assign tx_hit = count_nxt < {1'b0, ae_lvl};

    // Output decode per mode
    always_comb begin
        rx_req_d = 1'b0;
        tx_req_d = 1'b0;
        af_d     = 1'b0;
        ae_d     = 1'b0;
        unique case (mode)
            LM_IDLE: begin
                rx_req_d = 1'b0;
            end
            LM_RX: begin
                rx_req_d = rx_hit && rx_en;
                af_d     = rx_hit && !rx_en;
            end
            LM_TX: begin
                tx_req_d = tx_hit && tx_en;
                ae_d     = tx_hit && !tx_en;
            end
            default: begin
                rx_req_d = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_req  <= 1'b0;
            tx_req  <= 1'b0;
            af_flag <= 1'b0;
            ae_flag <= 1'b0;
        end else begin
            rx_req  <= rx_req_d;
            tx_req  <= tx_req_d;
            af_flag <= af_d;
            ae_flag <= ae_d;
        end
    end

endmodule

// File: rtl/lvl_fifo_top.sv
`timescale 1ns/1ps
module lvl_fifo_top #(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dir_rx,
    input  logic              xfer_active,
    input  logic              host_push,
    input  logic [DATA_W-1:0] host_wdata,
    input  logic              host_pop,
    input  logic              card_push,
    input  logic [DATA_W-1:0] card_wdata,
    input  logic              card_pop,
    input  logic              cfg_wr,
    input  logic [ADDR_W-1:0] cfg_af_level,
    input  logic [ADDR_W-1:0] cfg_ae_level,
    input  logic              cfg_rx_dma,
    input  logic              cfg_tx_dma,
    output logic [ADDR_W:0]   occupancy,
    output logic [DATA_W-1:0] head_data,
    output logic              rx_dma_req,
    output logic              tx_dma_req,
    output logic              af_flag,
    output logic              ae_flag
);
    localparam logic [ADDR_W-1:0] AF_RESET = '1;
    localparam logic [ADDR_W-1:0] AE_RESET = '0;

    logic              push_req, pop_req, push_ok, pop_ok;
    logic [DATA_W-1:0] push_data;
    logic [ADDR_W:0]   count_nxt;

    logic [ADDR_W-1:0] af_q, ae_q, af_eff, ae_eff;
    logic              rxen_q, txen_q, rxen_eff, txen_eff;

    // Direction steering of strobes and data
    assign push_req  = dir_rx ? card_push  : host_push;
    assign push_data = dir_rx ? card_wdata : host_wdata;
    assign pop_req   = dir_rx ? host_pop   : card_pop;

    // Configuration holding registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            af_q   <= AF_RESET;
            ae_q   <= AE_RESET;
            rxen_q <= 1'b0;
            txen_q <= 1'b0;
        end else if (cfg_wr) begin
            af_q   <= cfg_af_level;
            ae_q   <= cfg_ae_level;
            rxen_q <= cfg_rx_dma;
            txen_q <= cfg_tx_dma;
        end
    end

    // Settings that hold after this edge
    assign af_eff   = cfg_wr ? cfg_af_level : af_q;
    assign ae_eff   = cfg_wr ? cfg_ae_level : ae_q;
    assign rxen_eff = cfg_wr ? cfg_rx_dma   : rxen_q;
    assign txen_eff = cfg_wr ? cfg_tx_dma   : txen_q;

    lvl_fifo_fill #(.ADDR_W(ADDR_W)) u_fill (
        .clk       (clk),
        .rst_n     (rst_n),
        .push_req  (push_req),
        .pop_req   (pop_req),
        .push_ok   (push_ok),
        .pop_ok    (pop_ok),
        .count     (occupancy),
        .count_nxt (count_nxt)
    );

    lvl_fifo_store #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (push_ok),
        .wr_data (push_data),
        .rd_en   (pop_ok),
        .head    (head_data)
    );

    lvl_fifo_level #(.ADDR_W(ADDR_W)) u_level (
        .clk         (clk),
        .rst_n       (rst_n),
        .count_nxt   (count_nxt),
        .dir_rx      (dir_rx),
        .xfer_active (xfer_active),
        .af_lvl      (af_eff),
        .ae_lvl      (ae_eff),
        .rx_en       (rxen_eff),
        .tx_en       (txen_eff),
        .rx_req      (rx_dma_req),
        .tx_req      (tx_dma_req),
        .af_flag     (af_flag),
        .ae_flag     (ae_flag)
    );

endmodule

// File: rtl/lvl_fifo_chk.sv
`timescale 1ns/1ps
module lvl_fifo_chk #(
    parameter int ADDR_W = 5
) (
    input logic            clk,
    input logic            rst_n,
    input logic            dir_rx,
    input logic            xfer_active,
    input logic            host_push,
    input logic            host_pop,
    input logic            card_push,
    input logic            card_pop,
    input logic [ADDR_W:0] occupancy,
    input logic            rx_dma_req,
    input logic            tx_dma_req,
    input logic            af_flag,
    input logic            ae_flag
);
    localparam logic [ADDR_W:0] FULL_CNT = (ADDR_W+1)'(1 << ADDR_W);

    assert_occ_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
        occupancy <= FULL_CNT);

    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (occupancy == FULL_CNT && !dir_rx && host_push && !card_pop)
        |=> occupancy == FULL_CNT);

    assert_empty_pop_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (occupancy == '0 && !dir_rx && card_pop && !host_push)
        |=> occupancy == '0);

    assert_pair_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (dir_rx && card_push && host_pop && occupancy != '0)
        |=> $stable(occupancy));

    assert_rx_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(rx_dma_req && af_flag));

    assert_tx_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(tx_dma_req && ae_flag));

    assert_tx_dir_only_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(dir_rx) |-> (!tx_dma_req && !ae_flag));

    assert_rx_dir_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!dir_rx) |-> (!rx_dma_req && !af_flag));

    assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(!xfer_active) && occupancy == '0)
        |-> (!rx_dma_req && !tx_dma_req && !af_flag && !ae_flag));

endmodule

bind lvl_fifo_top lvl_fifo_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .dir_rx      (dir_rx),
    .xfer_active (xfer_active),
    .host_push   (host_push),
    .host_pop    (host_pop),
    .card_push   (card_push),
    .card_pop    (card_pop),
    .occupancy   (occupancy),
    .rx_dma_req  (rx_dma_req),
    .tx_dma_req  (tx_dma_req),
    .af_flag     (af_flag),
    .ae_flag     (ae_flag)
);

// File: tb/lvl_fifo_top_bench.sv
`timescale 1ns/1ps
module lvl_fifo_top_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        dir_rx = 1'b0, xfer_active = 1'b0;
    logic        host_push = 1'b0, host_pop = 1'b0, card_push = 1'b0, card_pop = 1'b0;
    logic [15:0] host_wdata = '0, card_wdata = '0;
    logic        cfg_wr = 1'b0, cfg_rx_dma = 1'b0, cfg_tx_dma = 1'b0;
    logic [4:0]  cfg_af_level = '0, cfg_ae_level = '0;
    logic [5:0]  occupancy;
    logic [15:0] head_data;
    logic        rx_dma_req, tx_dma_req, af_flag, ae_flag;

    int errs = 0;
    int checks = 0;

    // Bench model
    int          cnt = 0, wp = 0, rp = 0;
    logic [15:0] mq [32];
    int          maf = 31, mae = 0;
    bit          mrx = 0, mtx = 0;
    bit          e_rxq, e_txq, e_af, e_ae;

    always #2 clk = ~clk;

    lvl_fifo_top u_lvl_fifo_top (
        .clk(clk), .rst_n(rst_n), .dir_rx(dir_rx), .xfer_active(xfer_active),
        .host_push(host_push), .host_wdata(host_wdata), .host_pop(host_pop),
        .card_push(card_push), .card_wdata(card_wdata), .card_pop(card_pop),
        .cfg_wr(cfg_wr), .cfg_af_level(cfg_af_level), .cfg_ae_level(cfg_ae_level),
        .cfg_rx_dma(cfg_rx_dma), .cfg_tx_dma(cfg_tx_dma),
        .occupancy(occupancy), .head_data(head_data),
        .rx_dma_req(rx_dma_req), .tx_dma_req(tx_dma_req),
        .af_flag(af_flag), .ae_flag(ae_flag)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errs++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic check_all(input string tag);
        chk({tag, " occupancy"}, int'(occupancy), cnt);
        chk({tag, " rx_dma_req"}, int'(rx_dma_req), int'(e_rxq));
        chk({tag, " af_flag"}, int'(af_flag), int'(e_af));
        chk({tag, " tx_dma_req"}, int'(tx_dma_req), int'(e_txq));
        chk({tag, " ae_flag"}, int'(ae_flag), int'(e_ae));
        if (cnt > 0) chk({tag, " head_data"}, int'(head_data), int'(mq[rp]));
    endtask

    // One clock: model advances with the edge, then outputs are checked
    task automatic cyc(input string tag);
        bit psh, pp, pop_ok, psh_ok, idle, rxc, txc;
        logic [15:0] d;
        @(posedge clk);
        psh = dir_rx ? card_push : host_push;
        pp  = dir_rx ? host_pop  : card_pop;
        d   = dir_rx ? card_wdata : host_wdata;
        if (cfg_wr) begin
            maf = int'(cfg_af_level); mae = int'(cfg_ae_level);
            mrx = cfg_rx_dma; mtx = cfg_tx_dma;
        end
        pop_ok = pp && cnt > 0;
        psh_ok = psh && (cnt < 32 || pop_ok);
        if (psh_ok) begin mq[wp] = d; wp = (wp + 1) % 32; cnt++; end
        if (pop_ok) begin rp = (rp + 1) % 32; cnt--; end
        idle = !xfer_active && cnt == 0;
        rxc = !idle && dir_rx && cnt > maf;
        txc = !idle && !dir_rx && cnt < mae;
        e_rxq = rxc && mrx; e_af = rxc && !mrx;
        e_txq = txc && mtx; e_ae = txc && !mtx;
        #1;
        check_all(tag);
        host_push = 0; host_pop = 0; card_push = 0; card_pop = 0; cfg_wr = 0;
    endtask

    task automatic set_cfg(input int af, input int ae, input bit rx, input bit tx, input string tag);
        cfg_af_level = 5'(af); cfg_ae_level = 5'(ae);
        cfg_rx_dma = rx; cfg_tx_dma = tx; cfg_wr = 1;
        cyc(tag);
    endtask

    initial begin
        #(4 * 200000);
        errs++; checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        e_rxq = 0; e_txq = 0; e_af = 0; e_ae = 0;
        repeat (3) @(posedge clk);
        #1;
        check_all("R9 reset");
        rst_n = 1;
        xfer_active = 1;
        dir_rx = 1;
        cyc("R9 idle after reset");

        // R9: reset high-water is 31, no DMA -> flag only at 32
        for (int k = 0; k < 32; k++) begin
            card_push = 1; card_wdata = 16'(16'h1000 + k);
            cyc("R9 reset threshold fill");
        end
        chk("R9 af_flag at 32", int'(af_flag), 1);
        for (int k = 0; k < 32; k++) begin
            host_pop = 1; cyc("R1 rx drain order");
        end

        // R1 order and wrap, host-to-card
        dir_rx = 0;
        for (int k = 0; k < 20; k++) begin
            host_push = 1; host_wdata = 16'(16'hA000 + k); cyc("R1 fill");
        end
        for (int k = 0; k < 20; k++) begin
            card_pop = 1; cyc("R1 drain");
        end
        for (int k = 0; k < 32; k++) begin
            host_push = 1; host_wdata = 16'(16'hB000 + 3 * k); cyc("R1 wrap fill");
        end
        chk("R1 full count", int'(occupancy), 32);

        // R3 drop at full, R5 pair at full
        host_push = 1; host_wdata = 16'hDEAD; cyc("R3 push at full dropped");
        host_push = 1; host_wdata = 16'hBEEF; card_pop = 1; cyc("R5 push+pop at full");
        chk("R5 count kept", int'(occupancy), 32);

        // R2 off-direction strobes ignored
        card_push = 1; card_wdata = 16'h5555; host_pop = 1; cyc("R2 tx ignores card_push/host_pop");
        dir_rx = 1;
        host_push = 1; host_wdata = 16'h6666; card_pop = 1; cyc("R2 rx ignores host_push/card_pop");
        dir_rx = 0;
        for (int k = 0; k < 32; k++) begin
            card_pop = 1; cyc("R1 wrap drain order");
        end

        // R4 pop on empty: head stays at the entry under the read pointer
        card_pop = 1; cyc("R4 empty pop");
        chk("R4 empty head", int'(head_data), int'(mq[rp]));
        card_pop = 1; cyc("R4 empty pop again");
        chk("R4 head unchanged", int'(head_data), int'(mq[rp]));

        // R5 pair with partial occupancy, card-to-host
        dir_rx = 1;
        card_push = 1; card_wdata = 16'h0101; cyc("R5 prefill");
        card_push = 1; card_wdata = 16'h0202; host_pop = 1; cyc("R5 pair partial");
        host_pop = 1; cyc("R5 drain");

        // R10: flag cleared at the same edge DMA enable is loaded
        set_cfg(2, 0, 0, 0, "R10 cfg no dma");
        for (int k = 0; k < 3; k++) begin
            card_push = 1; card_wdata = 16'(k); cyc("R6 rise above 2");
        end
        chk("R10 af before enable", int'(af_flag), 1);
        set_cfg(2, 0, 1, 0, "R10 enable rx dma");
        chk("R10 af cleared", int'(af_flag), 0);
        chk("R10 rx req set", int'(rx_dma_req), 1);
        for (int k = 0; k < 3; k++) begin
            host_pop = 1; cyc("R6 drain");
        end

        // R6 sweep over every high-water value
        for (int af = 0; af < 32; af++) begin
            set_cfg(af, 0, af[0], 0, "R6 cfg");
            for (int k = 0; k < 32; k++) begin
                card_push = 1; card_wdata = 16'(af * 64 + k); cyc("R6 sweep fill");
            end
            for (int k = 0; k < 32; k++) begin
                host_pop = 1; cyc("R6 sweep drain");
            end
        end

        // R7/R8 sweep over every low-water value
        dir_rx = 0;
        for (int ae = 0; ae < 32; ae++) begin
            set_cfg(31, ae, 0, ae[0], "R7 cfg");
            for (int k = 0; k < 32; k++) begin
                host_push = 1; host_wdata = 16'(ae * 128 + k); cyc("R7 sweep fill");
            end
            for (int k = 0; k < 32; k++) begin
                card_pop = 1; cyc("R7 sweep drain");
            end
            xfer_active = 0; cyc("R8 idle empty");
            xfer_active = 1; cyc("R7 active empty");
        end

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule